// File: doc/BRIEF.md
# Frame-Synchronous Window Register Bank

This block holds the configuration of five overlay windows for a display pipeline. Each window has three registers: a control word, a position word and a frame-buffer base address. Each register exists twice. Software writes reach only the pending copy. The active copy drives the pipeline, and it takes the pending value only on a vertical-sync strobe. This means a window never changes part-way through a frame.

Software can hold back the vsync transfer of any window through a protect mask. With its bit set, a window keeps its active registers at every vsync. Software can then rewrite all of that window's registers. After software clears the bit, the whole set moves to the active copy together at the next vsync. Both copies can be read back over the bus, so software can compare the active base address with the pending one to see whether a flip has taken place.

The bus address is six bits, laid out as {copy, slot[2:0], reg[1:0]}:
- The copy bit selects pending (0) or active (1).
- Slots 0 to 4 are the windows, and slot 7 is the protect mask.
- Reg 0 is the control word, reg 1 the position and reg 2 the base address.

Control bit 0 enables the window and control bit 1 enables its channel. Reads are combinational from the address.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every pending and active control and position word reads 0, every base address reads 0x0000_1000, the protect mask (slot 7, reg 0) reads 0, and all window-live outputs are 0.
- R2: A write with the copy bit 0 to slot 0..4, reg 0..2, changes that pending register in the next cycle. The active copy and the live outputs stay unchanged until a vsync.
- R3: On a vsync strobe, each unprotected window copies its pending control, position and base words into the active copy. The result is visible on the active outputs in the next cycle.
- R4: While a window's protect bit (mask bit w for window w) is set, vsync leaves its active registers unchanged. The first vsync after the bit is cleared copies them.
- R5: All registers of a window written while it was protected reach the active copy in one and the same vsync.
- R6: A change of the enable bit (control bit 0), including clearing it, shows on win_live_o only after the next vsync.
- R7: win_live_o[w] is 1 exactly when the active control word of window w has both bit 0 (window enable) and bit 1 (channel enable) set.
- R8: The active base address reads back separately from the pending one (copy bit 1). After a vsync on an unprotected window, the two read equal.
- R9: A write that falls in a vsync cycle reaches the pending copy, while the transfer in that cycle moves the value pending before the write. A protect-mask write in a vsync cycle takes effect only from the next cycle.
- R10: Writes with the copy bit 1, to slots 5 and 6, to reg 3, or to slot 7 with a reg other than 0, change no register.
- R11: Protect bits act per window. Unprotected windows transfer at a vsync in which other windows are protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vsync_i | input | 1 | One-cycle vertical-sync strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register address {copy, slot, reg} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| act_ctrl_o | output | 160 | Active control words, window w at bits [32w+31:32w] |
| act_pos_o | output | 160 | Active position words, same packing |
| act_base_o | output | 160 | Active base addresses, same packing |
| win_live_o | output | 5 | Per-window path live (enable and channel enable active) |

## Verification
The critical overlap is a bus write or a protect-mask change landing in the same cycle as the vsync strobe. In that cycle the transfer must use the old pending values and the old mask, while the write still reaches the pending copy. Directed steps drive a base write together with vsync, and a protect write together with vsync. The random phase produces many more such collisions by raising writes and vsync independently. In every case a cycle-level bench model fixes the result: it applies the transfer before the write. Every step compares all active outputs against this model, and periodic bus sweeps compare both copies.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned SLOT_W  = 3;
  localparam int unsigned CTRL_EN = 0;
  localparam int unsigned CTRL_CH = 1;
  localparam logic [SLOT_W-1:0] PROT_SLOT = '1;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_POS  = 2'd1,
    REG_BASE = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                active_half;
    logic [SLOT_W-1:0]   slot;
    reg_sel_e            sel;
  } bank_addr_t;
endpackage

// File: rtl/shadow_addr_dec.sv
module shadow_addr_dec
  import shadow_bank_pkg::*;
#(
  parameter int unsigned NWIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NWIN-1:0]   win_we_o,
  output logic              prot_we_o,
  output reg_sel_e          sel_o
);
  bank_addr_t a;
  logic       pend_wr;

  assign a       = bank_addr_t'(addr_i);
  assign sel_o   = a.sel;
  assign pend_wr = we_i & ~a.active_half;

  for (genvar g = 0; g < NWIN; g++) begin : g_win_we
    assign win_we_o[g] = pend_wr & (a.slot == SLOT_W'(g)) & (a.sel != REG_NONE);
  end

  assign prot_we_o = pend_wr & (a.slot == PROT_SLOT) & (a.sel == REG_CTRL);

  // R10: at most one destination per bus write
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_we_o, prot_we_o}));
endmodule

// File: rtl/shadow_win_regs.sv
module shadow_win_regs
  import shadow_bank_pkg::*;
#(
  parameter int unsigned    DW       = 32,
  parameter logic [DW-1:0]  CTRL_RST = '0,
  parameter logic [DW-1:0]  POS_RST  = '0,
  parameter logic [DW-1:0]  BASE_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync_i,
  input  logic          protect_i,
  input  logic          we_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] pend_ctrl_o,
  output logic [DW-1:0] pend_pos_o,
  output logic [DW-1:0] pend_base_o,
  output logic [DW-1:0] act_ctrl_o,
  output logic [DW-1:0] act_pos_o,
  output logic [DW-1:0] act_base_o
);
  logic [DW-1:0] pc_q, pp_q, pb_q, pc_d, pp_d, pb_d;
  logic [DW-1:0] ac_q, ap_q, ab_q;
  logic          xfer_en;

  assign xfer_en = vsync_i & ~protect_i;

  always_comb begin
    pc_d = pc_q;
    pp_d = pp_q;
    pb_d = pb_q;
    if (we_i) begin
      case (sel_i)
        REG_CTRL: pc_d = wdata_i;
        REG_POS:  pp_d = wdata_i;
        REG_BASE: pb_d = wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= CTRL_RST;
      pp_q <= POS_RST;
      pb_q <= BASE_RST;
    end else if (we_i) begin
      pc_q <= pc_d;
      pp_q <= pp_d;
      pb_q <= pb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= CTRL_RST;
      ap_q <= POS_RST;
      ab_q <= BASE_RST;
    end else if (xfer_en) begin
      ac_q <= pc_q;
      ap_q <= pp_q;
      ab_q <= pb_q;
    end
  end

  assign pend_ctrl_o = pc_q;
  assign pend_pos_o  = pp_q;
  assign pend_base_o = pb_q;
  assign act_ctrl_o  = ac_q;
  assign act_pos_o   = ap_q;
  assign act_base_o  = ab_q;

  // R4: protected window holds its active copy through vsync
  assert_protect_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_i && protect_i) |=> ($stable(ac_q) && $stable(ap_q) && $stable(ab_q)));
  // R2: without vsync the active copy never moves
  assert_no_vsync_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_i |=> ($stable(ac_q) && $stable(ap_q) && $stable(ab_q)));
  // R5: all three registers move together in one vsync
  assert_set_atomic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_i && !protect_i) |=> (ac_q == $past(pc_q) && ap_q == $past(pp_q) && ab_q == $past(pb_q)));
  // R9: write data lands in pending copy regardless of vsync
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == REG_BASE) |=> pb_q == $past(wdata_i));
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int unsigned    NWIN     = 5,
  parameter int unsigned    DW       = 32,
  parameter logic [DW-1:0]  CTRL_RST = '0,
  parameter logic [DW-1:0]  POS_RST  = '0,
  parameter logic [DW-1:0]  BASE_RST = DW'(32'h0000_1000)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic [NWIN*DW-1:0] act_ctrl_o,
  output logic [NWIN*DW-1:0] act_pos_o,
  output logic [NWIN*DW-1:0] act_base_o,
  output logic [NWIN-1:0]    win_live_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NWIN-1:0] win_we;
  logic            prot_we;
  reg_sel_e        sel;
  bank_addr_t      ra;

  shadow_addr_dec #(.NWIN(NWIN)) i_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .win_we_o  (win_we),
    .prot_we_o (prot_we),
    .sel_o     (sel)
  );

  logic [NWIN-1:0] prot_q, prot_d;

  always_comb begin
    prot_d = prot_q;
    if (prot_we) prot_d = bus_wdata_i[NWIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  prot_q <= '0;
    else if (prot_we) prot_q <= prot_d;
  end

  logic [DW-1:0] pc [NWIN];
  logic [DW-1:0] pp [NWIN];
  logic [DW-1:0] pb [NWIN];
  logic [DW-1:0] ac [NWIN];
  logic [DW-1:0] ap [NWIN];
  logic [DW-1:0] ab [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    shadow_win_regs #(
      .DW(DW), .CTRL_RST(CTRL_RST), .POS_RST(POS_RST), .BASE_RST(BASE_RST)
    ) i_win (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .vsync_i     (vsync_i),
      .protect_i   (prot_q[w]),
      .we_i        (win_we[w]),
      .sel_i       (sel),
      .wdata_i     (bus_wdata_i),
      .pend_ctrl_o (pc[w]),
      .pend_pos_o  (pp[w]),
      .pend_base_o (pb[w]),
      .act_ctrl_o  (ac[w]),
      .act_pos_o   (ap[w]),
      .act_base_o  (ab[w])
    );

    assign act_ctrl_o[w*DW +: DW] = ac[w];
    assign act_pos_o[w*DW +: DW]  = ap[w];
    assign act_base_o[w*DW +: DW] = ab[w];
    assign win_live_o[w] = ac[w][CTRL_EN] & ac[w][CTRL_CH];

    // R6: a window only comes alive on a vsync
    assert_live_rise_at_vsync_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(win_live_o[w]) |-> $past(vsync_i));
    // R6: and only goes dark on a vsync
    assert_live_fall_at_vsync_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(win_live_o[w]) |-> $past(vsync_i));
  end

  assign ra = bank_addr_t'(bus_addr_i);

  always_comb begin
    bus_rdata_o = '0;
    if (ra.slot == PROT_SLOT) begin
      if (!ra.active_half && ra.sel == REG_CTRL)
        bus_rdata_o = {{(DW-NWIN){1'b0}}, prot_q};
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (ra.slot == SLOT_W'(w)) begin
          case (ra.sel)
            REG_CTRL: bus_rdata_o = ra.active_half ? ac[w] : pc[w];
            REG_POS:  bus_rdata_o = ra.active_half ? ap[w] : pp[w];
            REG_BASE: bus_rdata_o = ra.active_half ? ab[w] : pb[w];
            default:  bus_rdata_o = '0;
          endcase
        end
      end
    end
  end

  // R9: protect mask moves only on its own write
  assert_prot_write_only_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !prot_we |=> $stable(prot_q));
endmodule

// File: tb/test_vsync_shadow_bank.sv
module test_vsync_shadow_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vsync = 1'b0;
  logic         bus_we = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [159:0] act_ctrl, act_pos, act_base;
  logic [4:0]   live;

  always #10 clk = ~clk;

  vsync_shadow_bank i_vsync_shadow_bank (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .act_ctrl_o(act_ctrl), .act_pos_o(act_pos), .act_base_o(act_base),
    .win_live_o(live)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_pend [5][3];
  logic [31:0] m_act  [5][3];
  logic [4:0]  m_prot;

  task automatic chk(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [5:0] adr(bit act_half, int slot, int r);
    return {act_half, 3'(slot), 2'(r)};
  endfunction

  task automatic cmp_out(string req);
    for (int w = 0; w < 5; w++) begin
      chk(act_ctrl[w*32 +: 32] == m_act[w][0], req, $sformatf("act ctrl w%0d", w), act_ctrl[w*32 +: 32], m_act[w][0]);
      chk(act_pos[w*32 +: 32]  == m_act[w][1], req, $sformatf("act pos w%0d", w),  act_pos[w*32 +: 32],  m_act[w][1]);
      chk(act_base[w*32 +: 32] == m_act[w][2], req, $sformatf("act base w%0d", w), act_base[w*32 +: 32], m_act[w][2]);
      chk(live[w] == (m_act[w][0][0] & m_act[w][0][1]), req, $sformatf("live w%0d", w),
          32'(live[w]), 32'(m_act[w][0][0] & m_act[w][0][1]));
    end
  endtask

  task automatic step(bit we, logic [5:0] a, logic [31:0] d, bit vs, string req);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; vsync = vs;
    @(posedge clk);
    if (vs)
      for (int w = 0; w < 5; w++)
        if (!m_prot[w])
          for (int r = 0; r < 3; r++) m_act[w][r] = m_pend[w][r];
    if (we && !a[5]) begin
      if (a[4:2] < 3'd5 && a[1:0] != 2'd3) m_pend[a[4:2]][a[1:0]] = d;
      else if (a[4:2] == 3'd7 && a[1:0] == 2'd0) m_prot = d[4:0];
    end
    @(negedge clk);
    bus_we = 1'b0; vsync = 1'b0;
    cmp_out(req);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b0; vsync = 1'b0; bus_addr = a;
    #2;
    v = bus_rdata;
  endtask

  task automatic sweep(string req);
    logic [31:0] v;
    for (int w = 0; w < 5; w++)
      for (int r = 0; r < 3; r++) begin
        rd(adr(0, w, r), v);
        chk(v == m_pend[w][r], req, $sformatf("pend rd w%0d r%0d", w, r), v, m_pend[w][r]);
        rd(adr(1, w, r), v);
        chk(v == m_act[w][r], req, $sformatf("act rd w%0d r%0d", w, r), v, m_act[w][r]);
      end
    rd(adr(0, 7, 0), v);
    chk(v == 32'(m_prot), req, "protect rd", v, 32'(m_prot));
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 5; w++) begin
      m_pend[w] = '{32'h0, 32'h0, 32'h0000_1000};
      m_act[w]  = '{32'h0, 32'h0, 32'h0000_1000};
    end
    m_prot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_out("R1");
    sweep("R1");

    // R2: pending write, active untouched
    step(1, adr(0, 2, 2), 32'hA000_0040, 0, "R2");
    sweep("R2");

    // R6: enable change needs vsync
    step(1, adr(0, 2, 0), 32'h3, 0, "R6");
    step(0, '0, '0, 1, "R6");
    step(1, adr(0, 2, 0), 32'h2, 0, "R6");
    step(0, '0, '0, 1, "R6");

    // R7: channel enable and window enable both needed
    step(1, adr(0, 0, 0), 32'h1, 0, "R7");
    step(0, '0, '0, 1, "R7");
    step(1, adr(0, 0, 0), 32'h2, 0, "R7");
    step(0, '0, '0, 1, "R7");
    step(1, adr(0, 0, 0), 32'h3, 0, "R7");
    step(0, '0, '0, 1, "R7");

    // R4 / R5 / R11: protected multi-register update
    step(1, adr(0, 7, 0), 32'h0000_0002, 0, "R4");
    step(1, adr(0, 1, 0), 32'h0000_0033, 0, "R5");
    step(1, adr(0, 1, 1), 32'h0040_0020, 0, "R5");
    step(1, adr(0, 1, 2), 32'h8000_0000, 0, "R5");
    step(1, adr(0, 3, 2), 32'h9000_0000, 0, "R11");
    step(0, '0, '0, 1, "R11");
    sweep("R4");
    step(1, adr(0, 7, 0), 32'h0, 0, "R4");
    step(0, '0, '0, 1, "R5");
    sweep("R5");

    // R8: flip confirmation via base readback
    step(1, adr(0, 4, 2), 32'hC0DE_0000, 0, "R8");
    rd(adr(0, 4, 2), v1); rd(adr(1, 4, 2), v2);
    chk(v1 != v2, "R8", "base copies differ before vsync", v2, v1);
    step(0, '0, '0, 1, "R8");
    rd(adr(0, 4, 2), v1); rd(adr(1, 4, 2), v2);
    chk(v1 == v2, "R8", "base copies equal after vsync", v2, v1);

    // R9: write and protect change in the vsync cycle
    step(1, adr(0, 0, 2), 32'h0000_0100, 0, "R9");
    step(1, adr(0, 0, 2), 32'h0000_0200, 1, "R9");
    step(0, '0, '0, 1, "R9");
    step(1, adr(0, 0, 2), 32'h0000_0300, 0, "R9");
    step(1, adr(0, 7, 0), 32'h0000_0001, 1, "R9");
    step(1, adr(0, 0, 2), 32'h0000_0400, 0, "R9");
    step(0, '0, '0, 1, "R9");
    step(1, adr(0, 7, 0), 32'h0, 0, "R9");
    sweep("R9");

    // R10: writes that must be ignored
    step(1, adr(1, 0, 2), 32'hDEAD_BEEF, 0, "R10");
    step(1, adr(0, 5, 0), 32'hDEAD_BEEF, 0, "R10");
    step(1, adr(0, 6, 1), 32'hDEAD_BEEF, 0, "R10");
    step(1, adr(0, 2, 3), 32'hDEAD_BEEF, 0, "R10");
    step(1, adr(0, 7, 1), 32'h0000_001F, 0, "R10");
    sweep("R10");

    // R3: random mix of writes, protect changes and vsync
    for (int i = 0; i < 800; i++) begin
      bit we = ($urandom % 4) != 0;
      bit half = ($urandom % 10) == 0;
      int slot = ($urandom % 6 == 0) ? 7 : int'($urandom % 7);
      int r = int'($urandom % 4);
      logic [31:0] d = $urandom;
      bit vs = ($urandom % 4) == 0;
      if (slot == 7) begin
        r = (($urandom % 4) == 0) ? 1 : 0;
        d = d & 32'h1F;
      end
      step(we, adr(half, slot, r), d, vs, "R3");
      if (i % 100 == 99) sweep("R3");
    end
    sweep("R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule